// File: doc/BRIEF.md
# Event-Stepped I2C Master with Status Codes

This block is an I2C bus master that software walks through a transfer one bus event at a time. Software writes a control register to request a START, a STOP or the transfer of one byte. When that event finishes on the wire, the block sets an event flag (also brought out as an interrupt), loads an 8-bit status code that names what happened, and holds SCL low until software asks for the next step. The transfer sequence is chosen entirely by software.

The register window has three byte-wide registers: control at offset 0x00, status at 0x04 and data at 0x08. The control byte holds, from bit 7 down: divider bit 2, enable, start request, stop request, event flag, acknowledge enable, divider bit 1 and divider bit 0. SCL and SDA are open drain. The block only ever pulls a line low through its `*_oe_o` outputs, and it reads SDA back through a two-stage synchroniser. One SCL period is split into four equal quarters. SDA is changed in the first quarter, SCL is released in the second, SDA is sampled in the third and SCL is pulled low in the fourth.

Top module: `i2c_evt_master`

## Requirements
- R1: After reset, control reads 0x00, status reads 0xF8, the interrupt is low and both bus lines are released.
- R2: The divider field {bit7,bit1,bit0} sets the SCL period in clock cycles: 000→256, 001→224, 010→192, 011→160, 100→960, 101→120, 110→60. The code 111 behaves as 110.
- R3: A start request (bit 5) written with enable set and the event flag written 0 produces a START and status 0x08. If the bus is already owned, it produces a repeated START and status 0x10. In both cases the event flag is set and bit 5 reads back 0.
- R4: The first byte after a START is the address byte, with the read/write bit in bit 0 (1 = read). It ends with 0x18 (write, ACK), 0x20 (write, NACK), 0x40 (read, ACK) or 0x48 (read, NACK).
- R5: A data byte in write direction is shifted out MSB first. It ends with 0x28 on ACK or 0x30 on NACK.
- R6: In read direction the acknowledge-enable bit (bit 2), as written when the byte is launched, selects whether the master drives ACK (status 0x50) or NACK (status 0x58). The received byte is in the data register when the event flag rises.
- R7: The event flag is cleared only by a control write with bit 3 at 0. Writing 1 to bit 3 leaves the flag unchanged. While the flag is set after an owned-bus event, SCL is held low and no bus activity starts.
- R8: A stop request (bit 4) generates a STOP condition, after which status reads 0xF8, the event flag stays low and bit 4 reads back 0.
- R9: If the master releases SDA to send a 1 and samples it low, it releases both lines, gives up the bus, sets the event flag and reports 0x38.
- R10: Clearing the enable bit (bit 6) aborts any activity. Both lines are released, status reads 0xF8 and the event flag is cleared.
- R11: A start request and a stop request written together while the bus is owned produce a STOP followed by a fresh START that reports 0x08.
- R12: During a byte transfer, SDA driven by the master changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data for addr_i (combinational) |
| irq_o | output | 1 | Event flag |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The case where two functions meet in one step is a single control write that carries both the stop request and the start request while the bus is owned. The STOP and the new START then run back to back inside one launch. The bench provokes this right after an acknowledged address byte. It judges the result by counting exactly one STOP at the bus model, reading status 0x08 rather than 0x10, and finding both request bits cleared in the control register. A second collision is a disable written in the middle of a byte. It must win over the shifting engine within a few cycles.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int CTL_EN  = 6;
  localparam int CTL_STA = 5;
  localparam int CTL_STO = 4;
  localparam int CTL_SI  = 3;
  localparam int CTL_AA  = 2;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_DW_NACK = 8'h30;
  localparam logic [7:0] ST_LOST    = 8'h38;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_DR_ACK  = 8'h50;
  localparam logic [7:0] ST_DR_NACK = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  typedef enum logic [2:0] {PH_IDLE, PH_HOLD, PH_START, PH_STOP, PH_BYTE} phase_e;

  // SCL period in clock cycles for a divider code
  function automatic int unsigned scl_div(input logic [2:0] sel);
    case (sel)
      3'b000:  return 256;
      3'b001:  return 224;
      3'b010:  return 192;
      3'b011:  return 160;
      3'b100:  return 960;
      3'b101:  return 120;
      default: return 60;
    endcase
  endfunction
endpackage

// File: rtl/i2c_evt_qtimer.sv
module i2c_evt_qtimer
  import i2c_evt_pkg::*;
#(
  parameter int QCNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [QCNT_W-1:0] cnt_q;
  logic [QCNT_W-1:0] qlen;

  assign qlen   = QCNT_W'(scl_div(sel_i) / 4 - 1);
  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= qlen;
    else if (cnt_q == '0)   cnt_q <= qlen;
    else                    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/i2c_evt_engine.sv
module i2c_evt_engine
  import i2c_evt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              go_i,
  input  logic              sta_i,
  input  logic              sto_i,
  input  logic              aa_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              sda_i,
  output logic              busy_o,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              evt_o,
  output logic              evt_si_o,
  output logic [7:0]        evt_code_o,
  output logic              rx_vld_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              clr_sta_o,
  output logic              clr_sto_o,
  output phase_e            phase_o
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(BYTE_W);

  phase_e            phase_q;
  logic [1:0]        q_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic owned_q, addr_q, rd_q, aa_q, ack_q, chain_q, scl_q, sda_q;
  logic evt_q, evt_si_q, rx_vld_q, clr_sta_q, clr_sto_q;
  logic [7:0] code_q;
  logic rx_mode;

  assign rx_mode = rd_q && !addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE; q_q <= '0; bit_q <= '0; sh_q <= '0;
      owned_q <= 1'b0; addr_q <= 1'b0; rd_q <= 1'b0; aa_q <= 1'b0;
      ack_q <= 1'b0; chain_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
      evt_q <= 1'b0; evt_si_q <= 1'b0; code_q <= ST_IDLE;
      rx_vld_q <= 1'b0; clr_sta_q <= 1'b0; clr_sto_q <= 1'b0;
    end else begin
      evt_q <= 1'b0; rx_vld_q <= 1'b0; clr_sta_q <= 1'b0; clr_sto_q <= 1'b0;
      if (!en_i) begin
        phase_q <= PH_IDLE; q_q <= '0; owned_q <= 1'b0; chain_q <= 1'b0;
        scl_q <= 1'b0; sda_q <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_IDLE: if (go_i && sta_i) begin phase_q <= PH_START; q_q <= '0; end
          PH_HOLD: if (go_i) begin
            q_q <= '0;
            if (sto_i) begin
              phase_q <= PH_STOP; chain_q <= sta_i;
            end else if (sta_i) begin
              phase_q <= PH_START;
            end else begin
              phase_q <= PH_BYTE; sh_q <= tx_i; bit_q <= '0; aa_q <= aa_i;
              if (addr_q) rd_q <= tx_i[0];
            end
          end
          PH_START: if (tick_i) begin
            q_q <= q_q + 1'b1;
            unique case (q_q)
              2'd0: sda_q <= 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b1;
              2'd3: begin
                scl_q <= 1'b1; phase_q <= PH_HOLD; owned_q <= 1'b1; addr_q <= 1'b1;
                evt_q <= 1'b1; evt_si_q <= 1'b1; clr_sta_q <= 1'b1;
                code_q <= owned_q ? ST_RSTART : ST_START;
              end
            endcase
          end
          PH_STOP: if (tick_i) begin
            q_q <= q_q + 1'b1;
            unique case (q_q)
              2'd0: sda_q <= 1'b1;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b0;
              2'd3: begin
                owned_q <= 1'b0; clr_sto_q <= 1'b1; chain_q <= 1'b0;
                if (chain_q) phase_q <= PH_START;
                else begin
                  phase_q <= PH_IDLE; evt_q <= 1'b1; evt_si_q <= 1'b0; code_q <= ST_IDLE;
                end
              end
            endcase
          end
          PH_BYTE: if (tick_i) begin
            q_q <= q_q + 1'b1;
            unique case (q_q)
              2'd0: begin
                if (bit_q == LAST) sda_q <= rx_mode ? aa_q : 1'b0;
                else               sda_q <= rx_mode ? 1'b0 : !sh_q[BYTE_W-1];
              end
              2'd1: scl_q <= 1'b0;
              2'd2: begin
                if (bit_q == LAST) ack_q <= !sda_i;
                else if (rx_mode)  sh_q <= {sh_q[BYTE_W-2:0], sda_i};
                else if (!sda_q && !sda_i) begin
                  // released a 1 but the line is low: another master won
                  phase_q <= PH_IDLE; owned_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
                  evt_q <= 1'b1; evt_si_q <= 1'b1; code_q <= ST_LOST;
                end
              end
              2'd3: begin
                scl_q <= 1'b1;
                if (bit_q == LAST) begin
                  phase_q <= PH_HOLD; addr_q <= 1'b0; evt_q <= 1'b1; evt_si_q <= 1'b1;
                  if (addr_q)       code_q <= rd_q ? (ack_q ? ST_AR_ACK : ST_AR_NACK)
                                                   : (ack_q ? ST_AW_ACK : ST_AW_NACK);
                  else if (rx_mode) begin
                    code_q <= aa_q ? ST_DR_ACK : ST_DR_NACK; rx_vld_q <= 1'b1;
                  end else          code_q <= ack_q ? ST_DW_ACK : ST_DW_NACK;
                end else begin
                  bit_q <= bit_q + 1'b1;
                  if (!rx_mode) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                end
              end
            endcase
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign busy_o     = (phase_q == PH_START) || (phase_q == PH_STOP) || (phase_q == PH_BYTE);
  assign scl_low_o  = scl_q;
  assign sda_low_o  = sda_q;
  assign evt_o      = evt_q;
  assign evt_si_o   = evt_si_q;
  assign evt_code_o = code_q;
  assign rx_vld_o   = rx_vld_q;
  assign rx_o       = sh_q;
  assign clr_sta_o  = clr_sta_q;
  assign clr_sto_o  = clr_sto_q;
  assign phase_o    = phase_q;
endmodule

// File: rtl/i2c_evt_master.sv
module i2c_evt_master
  import i2c_evt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int QCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  output logic              irq_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(8);

  logic [7:0] ctl_q, stat_q, dat_q;
  logic [1:0] sda_sync_q;
  logic       go_q, wr_ctl, tick, busy;
  logic       evt, evt_si, rx_vld, clr_sta, clr_sto;
  logic [7:0] evt_code, rx_byte;
  phase_e     eng_phase;

  assign wr_ctl = wr_en_i && (addr_i == A_CTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_sync_q <= 2'b11;
    else         sda_sync_q <= {sda_sync_q[0], sda_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0; stat_q <= ST_IDLE; dat_q <= '0; go_q <= 1'b0;
    end else begin
      go_q <= wr_ctl && wr_data_i[CTL_EN] && !wr_data_i[CTL_SI];
      if (wr_ctl) begin
        ctl_q         <= wr_data_i;
        ctl_q[CTL_SI] <= ctl_q[CTL_SI] && wr_data_i[CTL_SI] && wr_data_i[CTL_EN];
      end
      if (clr_sta)       ctl_q[CTL_STA] <= 1'b0;
      if (clr_sto)       ctl_q[CTL_STO] <= 1'b0;
      if (evt && evt_si) ctl_q[CTL_SI]  <= 1'b1;
      if (!ctl_q[CTL_EN]) stat_q <= ST_IDLE;
      else if (evt)       stat_q <= evt_code;
      if (wr_en_i && addr_i == A_DAT) dat_q <= wr_data_i;
      if (rx_vld)                     dat_q <= rx_byte;
    end
  end

  i2c_evt_qtimer #(.QCNT_W(QCNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .sel_i  ({ctl_q[7], ctl_q[1], ctl_q[0]}),
    .tick_o (tick)
  );

  i2c_evt_engine #(.BYTE_W(8)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctl_q[CTL_EN]),
    .go_i       (go_q),
    .sta_i      (ctl_q[CTL_STA]),
    .sto_i      (ctl_q[CTL_STO]),
    .aa_i       (ctl_q[CTL_AA]),
    .tx_i       (dat_q),
    .tick_i     (tick),
    .sda_i      (sda_sync_q[1]),
    .busy_o     (busy),
    .scl_low_o  (scl_oe_o),
    .sda_low_o  (sda_oe_o),
    .evt_o      (evt),
    .evt_si_o   (evt_si),
    .evt_code_o (evt_code),
    .rx_vld_o   (rx_vld),
    .rx_o       (rx_byte),
    .clr_sta_o  (clr_sta),
    .clr_sto_o  (clr_sto),
    .phase_o    (eng_phase)
  );

  always_comb begin
    unique case (addr_i)
      A_CTL:   rd_data_o = ctl_q;
      A_STAT:  rd_data_o = stat_q;
      A_DAT:   rd_data_o = dat_q;
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = ctl_q[CTL_SI];
endmodule

// File: rtl/i2c_evt_master_chk.sv
module i2c_evt_master_chk
  import i2c_evt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wr_data_i,
  input logic              irq_o,
  input logic              scl_oe_o,
  input logic              sda_oe_o,
  input logic              en_q,
  input logic [7:0]        stat_q,
  input phase_e            phase
);
  p_si_holds_scl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && stat_q != ST_LOST) |-> scl_oe_o);

  p_si_clear_by_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_en_i && addr_i == '0 && (!wr_data_i[CTL_SI] || !wr_data_i[CTL_EN])));

  p_idle_no_si_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q == ST_IDLE) |-> !irq_o);

  p_lost_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && stat_q == ST_LOST) |-> (!scl_oe_o && !sda_oe_o));

  p_disable_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (!scl_oe_o && !sda_oe_o));

  p_sda_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_BYTE && !scl_oe_o && $past(!scl_oe_o)) |-> $stable(sda_oe_o));
endmodule

bind i2c_evt_master i2c_evt_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .en_q      (ctl_q[6]),
  .stat_q    (stat_q),
  .phase     (eng_phase)
);

// File: tb/i2c_evt_master_bench.sv
module i2c_evt_master_bench;
  localparam logic [7:0] EN = 8'h40, STA = 8'h20, STO = 8'h10, SI = 8'h08, AA = 8'h04;
  localparam logic [7:0] BASE = EN | 8'h82;   // divider code 110
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wen = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_low = 1'b0, jam = 1'b0;
  wire  scl_bus = !scl_oe;
  wire  sda_bus = !(sda_oe || slv_low || jam);

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  i2c_evt_master u_i2c_evt_master (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wen), .wr_data_i(wdata),
    .rd_data_o(rdata), .irq_o(irq), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_bus)
  );

  // behavioural slave answering address SLV
  bit s_act = 0, s_wait = 0, s_first = 0, s_match = 0, s_read = 0, s_mack = 0;
  int s_cnt = 0, rd_idx = 0, stop_cnt = 0;
  logic [7:0] s_sh = '0, s_tx = '0, last_wr = '0;
  wire txm = s_match && s_read && !s_first;

  always @(negedge sda_bus) if (scl_bus) begin
    s_act = 1; s_wait = 1; s_cnt = 0; s_first = 1; s_match = 0; s_read = 0; s_mack = 0; slv_low = 0;
  end
  always @(posedge sda_bus) if (scl_bus && s_act) begin
    s_act = 0; slv_low = 0; stop_cnt++;
  end
  always @(posedge scl_bus) if (s_act && !s_wait) begin
    if (s_cnt < 8) begin if (!txm) s_sh = {s_sh[6:0], sda_bus}; end
    else s_mack = !sda_bus;
  end
  always @(negedge scl_bus) if (s_act) begin
    if (s_wait) s_wait = 0;
    else if (s_cnt == 7) begin
      s_cnt = 8;
      if (txm) slv_low = 0;
      else begin
        if (s_first) begin s_match = (s_sh[7:1] == SLV); s_read = s_sh[0]; rd_idx = 0; end
        else if (s_match) last_wr = s_sh;
        slv_low = s_match;
      end
    end else if (s_cnt == 8) begin
      s_cnt = 0; slv_low = 0;
      if (s_match && s_read && (s_first || s_mack)) begin
        s_tx = 8'hC5 + 8'(8'h11 * rd_idx); rd_idx++; slv_low = !s_tx[7];
      end
      s_first = 0;
    end else begin
      s_cnt++;
      if (txm) slv_low = !s_tx[7 - s_cnt];
    end
  end

  // SCL period and R12 monitors
  int cyc = 0, last_rise = 0, last_per = 0, viol = 0;
  bit in_byte = 0, prev_scl = 1, prev_sda = 1;
  always @(negedge clk) begin
    if (scl_bus && !prev_scl) begin last_per = cyc - last_rise; last_rise = cyc; end
    if (in_byte && scl_bus && prev_scl && (sda_bus != prev_sda)) viol++;
    prev_scl = scl_bus; prev_sda = sda_bus; cyc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_si(input string req);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    in_byte = 0;
    if (!irq) chk(0, req, 0, 1);
  endtask

  task automatic step(input logic [7:0] c, input logic [7:0] exp, input string req);
    logic [7:0] st;
    wr(4'h0, c); wait_si(req); rd(4'h4, st);
    chk(st == exp, req, st, exp);
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] c, input logic [7:0] exp, input string req);
    wr(4'h8, b); in_byte = 1; step(c, exp, req);
  endtask

  task automatic recv(input bit ack, input logic [7:0] exp_d, input string req);
    logic [7:0] d;
    in_byte = 1;
    step(BASE | (ack ? AA : 8'h00), ack ? 8'h50 : 8'h58, req);
    rd(4'h8, d);
    chk(d == exp_d, req, d, exp_d);
  endtask

  task automatic stop_bus(input logic [7:0] c);
    logic [7:0] st = '0;
    int n = 0;
    int s0 = stop_cnt;
    wr(4'h0, c | STO);
    while (st != 8'hF8 && n < 20000) begin rd(4'h4, st); n++; end
    chk(st == 8'hF8 && !irq, "R8", {irq, st}, 8'hF8);
    chk(stop_cnt == s0 + 1, "R8", stop_cnt - s0, 1);
    rd(4'h0, st);
    chk(st == c, "R8", st, c);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(4'h0, v); chk(v == 8'h00, "R1", v, 8'h00);
    rd(4'h4, v); chk(v == 8'hF8, "R1", v, 8'hF8);
    chk(!irq && !scl_oe && !sda_oe, "R1", {irq, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_write;
    logic [7:0] v, st;
    step(BASE | STA, 8'h08, "R3");
    rd(4'h0, v); chk(v == (BASE | SI), "R3", v, BASE | SI);
    send({SLV, 1'b0}, BASE, 8'h18, "R4");
    repeat (300) @(negedge clk);                       // R7: held while flag set
    rd(4'h4, st);
    chk(scl_oe && irq && st == 8'h18, "R7", {scl_oe, irq}, 3);
    send(8'hA5, BASE, 8'h28, "R5");
    chk(last_wr == 8'hA5, "R5", last_wr, 8'hA5);
    stop_bus(BASE);
    wr(4'h0, BASE | SI);                               // R7: writing 1 to SI is ignored
    rd(4'h0, v);
    chk(v == BASE && !irq, "R7", v, BASE);
  endtask

  task automatic t_read;
    step(BASE | STA, 8'h08, "R3");
    send({SLV, 1'b1}, BASE, 8'h40, "R4");
    recv(1, 8'hC5, "R6");
    recv(0, 8'hD6, "R6");
    stop_bus(BASE);
  endtask

  task automatic t_restart;
    step(BASE | STA, 8'h08, "R3");
    send({SLV, 1'b0}, BASE, 8'h18, "R4");
    send(8'h3C, BASE, 8'h28, "R5");
    step(BASE | STA, 8'h10, "R3");
    send({SLV, 1'b1}, BASE, 8'h40, "R4");
    recv(0, 8'hC5, "R6");
    stop_bus(BASE);
  endtask

  task automatic t_nack;
    step(BASE | STA, 8'h08, "R3");
    send({7'h21, 1'b0}, BASE, 8'h20, "R4");
    stop_bus(BASE);
    step(BASE | STA, 8'h08, "R3");
    send({7'h21, 1'b1}, BASE, 8'h48, "R4");
    stop_bus(BASE);
  endtask

  task automatic t_div(input logic [7:0] c, input int exp);
    step(c | STA, 8'h08, "R2");
    last_per = 0;
    send({SLV, 1'b0}, c, 8'h18, "R2");
    chk(last_per == exp, "R2", last_per, exp);
    stop_bus(c);
  endtask

  task automatic t_arb;
    logic [7:0] st;
    step(BASE | STA, 8'h08, "R9");
    jam = 1'b1;
    wr(4'h8, {SLV, 1'b0});
    wr(4'h0, BASE);
    wait_si("R9");
    rd(4'h4, st);
    chk(st == 8'h38, "R9", st, 8'h38);
    chk(!scl_oe && !sda_oe, "R9", {scl_oe, sda_oe}, 0);
    jam = 1'b0;
    repeat (20) @(negedge clk);
    wr(4'h0, BASE);
  endtask

  task automatic t_disable;
    logic [7:0] st;
    step(BASE | STA, 8'h08, "R10");
    wr(4'h8, 8'hFF); wr(4'h0, BASE);
    repeat (100) @(negedge clk);
    wr(4'h0, 8'h00);
    repeat (3) @(negedge clk);
    rd(4'h4, st);
    chk(st == 8'hF8 && !irq, "R10", {irq, st}, 8'hF8);
    chk(!scl_oe && !sda_oe, "R10", {scl_oe, sda_oe}, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_combo;
    logic [7:0] v;
    int s0;
    step(BASE | STA, 8'h08, "R11");
    send({SLV, 1'b0}, BASE, 8'h18, "R11");
    s0 = stop_cnt;
    step(BASE | STA | STO, 8'h08, "R11");
    chk(stop_cnt == s0 + 1, "R11", stop_cnt - s0, 1);
    rd(4'h0, v);
    chk(v == (BASE | SI), "R11", v, BASE | SI);
    stop_bus(BASE);
  endtask

  initial begin
    int n = 0;
    while (n < 190000) begin @(negedge clk); n++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", n, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_read();
    t_restart();
    t_nack();
    t_div(BASE, 60);
    t_div(EN | 8'h00, 256);
    t_div(EN | 8'h80, 960);
    t_div(EN | 8'h83, 60);
    t_arb();
    t_disable();
    t_combo();
    chk(viol == 0, "R12", viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule